// File: doc/BRIEF.md
# Time-Triggered CAN Slave Cycle Synchronizer

This block follows the basic cycle of a time-triggered CAN network as a time slave. A CAN controller reports start-of-frame, a successful end of reception, whether the received frame is a reference message, the cycle count the frame carries and its gap flag. A free-running local time value is supplied alongside these events. From them the block keeps a reference mark, derives the cycle time as the distance from that mark, and copies the cycle count from each accepted reference. It never counts cycles on its own.

Six programmable time marks, each tied to one transmit slot, are compared against the cycle time, along with a mark for the expected reference slot. Each produces a single-cycle trigger. A watch compare guards against a missing reference. Until the first reference is accepted it uses the initial watch mark; after that it uses the normal watch mark. A hit sets a sticky error flag. A reference that announces a following gap raises a gap interrupt and arms a stop-transmit request. That request takes effect when the reference slot of the current cycle is reached.

Top module: `ttc_slave_sync`

## Requirements
- R1: At every `sof_evt` the local time is captured. When a reference is later accepted, `ref_mark` takes the value captured at the most recent start-of-frame, visible one cycle after `rx_ok_evt`.
- R2: Whenever `rx_ok_evt && rx_is_ref` is false, `ref_mark` and `cycle_cnt` hold their value. This covers a frame that started but never completed, and a successful frame that is not a reference. `cycle_time` therefore keeps following the same mark.
- R3: On an accepted reference, `cycle_cnt` (6 bits) loads `rx_cycle` one cycle later. It never increments by itself.
- R4: `cycle_time` equals `local_time - ref_mark` modulo 2^16, combinationally.
- R5: Bit i of `tmark_trig` pulses high for exactly one cycle, one cycle after the cycle time first equals `tmark[i]`. It pulses only after the first reference has been accepted. A held equality gives a single pulse.
- R6: `ref_slot_trig` behaves as in R5 against `ref_slot_mark`.
- R7: Before the first accepted reference, `init_watch_en`=1 and `watch_en`=0, and the watch compare uses `init_watch_mark`. From the cycle after the first acceptance onward, `init_watch_en`=0 and `watch_en`=1, and the compare uses `watch_mark`.
- R8: `watch_trig` pulses for one cycle, one cycle after the cycle time first equals the active watch mark. `wt_err` goes high the cycle after `watch_trig` and stays high. It is cleared by a cycle with `wt_err_clr`=1; a new watch hit wins over the clear.
- R9: `gap_irq` is a one-cycle pulse, one cycle after an accepted reference with `rx_gap`=1.
- R10: After a reference with `rx_gap`=1, `stop_tx` rises the cycle after the next `ref_slot_trig`. It stays high until the next accepted reference clears it. A reference with `rx_gap`=0 disarms the request.
- R11: While `rst_n` is low, and for two clock edges after it rises, all marks, the cycle count, the first-reference state, all triggers, `gap_irq`, `stop_tx` and `wt_err` are zero, and `init_watch_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| local_time | input | 16 | Free-running local time |
| sof_evt | input | 1 | Start-of-frame seen on the bus |
| rx_ok_evt | input | 1 | Frame received successfully |
| rx_is_ref | input | 1 | Completed frame is a reference message |
| rx_cycle | input | 6 | Cycle count carried by the completed frame |
| rx_gap | input | 1 | Completed reference announces a following gap |
| tmark | input | 6x16 | Time marks for the six transmit slots |
| ref_slot_mark | input | 16 | Expected reference slot mark |
| init_watch_mark | input | 16 | Watch mark used before first synchronization |
| watch_mark | input | 16 | Watch mark used after first synchronization |
| wt_err_clr | input | 1 | Write-one-to-clear for the watch error flag |
| ref_mark | output | 16 | Reference mark |
| cycle_time | output | 16 | Local time minus reference mark |
| cycle_cnt | output | 6 | Cycle count copied from the last reference |
| ref_seen | output | 1 | A reference has been accepted since reset |
| tmark_trig | output | 6 | Time mark trigger pulses |
| ref_slot_trig | output | 1 | Reference slot trigger pulse |
| init_watch_en | output | 1 | Initial watch compare active |
| watch_en | output | 1 | Normal watch compare active |
| watch_trig | output | 1 | Active watch compare hit pulse |
| wt_err | output | 1 | Sticky watch error |
| gap_irq | output | 1 | Gap interrupt pulse |
| stop_tx | output | 1 | Stop-transmit request |

## Verification
`cycle_time` is combinational and is due in the same cycle as `local_time` and `ref_mark`. The mark, count and watch-select state is due one edge after the accepting `rx_ok_evt`, and the triggers and `gap_irq` one edge after the causing condition. `wt_err` and `stop_tx` come one edge later still, because each is driven by a registered trigger. The bench drives inputs on the falling edge and advances a reference model across each rising edge using the inputs held at that edge. It then compares every output at the next falling edge, so each result is sampled exactly at the cycle where it is due. Idle cycles after reset release cover the two-edge reset synchronizer.

// File: rtl/ttc_pkg.sv
package ttc_pkg;
  parameter int unsigned TIME_W = 16;
  parameter int unsigned CYC_W  = 6;
  parameter int unsigned N_MARK = 6;
  // compare bank layout: transmit marks, then reference slot, then watch
  localparam int unsigned SLOT_IDX  = N_MARK;
  localparam int unsigned WATCH_IDX = N_MARK + 1;
  localparam int unsigned N_CMP     = N_MARK + 2;
endpackage

// File: rtl/ttc_rst_sync.sv
module ttc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ttc_ref_tracker.sv
module ttc_ref_tracker #(
  parameter int unsigned TW = 16,
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] local_time,
  input  logic          sof_evt,
  input  logic          rx_ok_evt,
  input  logic          rx_is_ref,
  input  logic [CW-1:0] rx_cycle,
  output logic [TW-1:0] ref_mark,
  output logic [CW-1:0] cycle_cnt,
  output logic          ref_seen,
  output logic          accept
);
  logic [TW-1:0] stamp_q, stamp_d;
  logic [TW-1:0] mark_q, mark_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;

  assign accept = rx_ok_evt && rx_is_ref;

  always_comb begin
    stamp_d = stamp_q;
    mark_d  = mark_q;
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    if (sof_evt) stamp_d = local_time;
    if (accept) begin
      mark_d = stamp_q;
      cnt_d  = rx_cycle;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      mark_q  <= '0;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
    end else begin
      stamp_q <= stamp_d;
      mark_q  <= mark_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
    end
  end

  assign ref_mark  = mark_q;
  assign cycle_cnt = cnt_q;
  assign ref_seen  = seen_q;

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cycle_cnt == $past(rx_cycle)));

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(ref_mark) && $stable(cycle_cnt)));

  // R7
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_seen |=> ref_seen);
endmodule

// File: rtl/ttc_cmp_bank.sv
module ttc_cmp_bank #(
  parameter int unsigned TW = 16,
  parameter int unsigned N  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TW-1:0]        cycle_time,
  input  logic [N-1:0][TW-1:0] marks,
  input  logic [N-1:0]         en,
  output logic [N-1:0]         trig
);
  for (genvar i = 0; i < N; i++) begin : g_slot
    logic hit, hit_q, trig_q, trig_d;

    always_comb begin
      hit    = en[i] && (cycle_time == marks[i]);
      trig_d = hit && !hit_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q  <= 1'b0;
        trig_q <= 1'b0;
      end else begin
        hit_q  <= hit;
        trig_q <= trig_d;
      end
    end

    assign trig[i] = trig_q;

    // R5
    trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig[i] |=> !trig[i]);
  end
endmodule

// File: rtl/ttc_watch_ctrl.sv
module ttc_watch_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic rx_gap,
  input  logic slot_trig,
  input  logic watch_hit,
  input  logic err_clr,
  output logic gap_irq,
  output logic stop_tx,
  output logic wt_err
);
  logic irq_q, irq_d;
  logic pend_q, pend_d;
  logic stop_q, stop_d;
  logic err_q, err_d;

  always_comb begin
    irq_d  = accept && rx_gap;
    pend_d = accept ? rx_gap : pend_q;
    if (accept)                 stop_d = 1'b0;
    else if (pend_q && slot_trig) stop_d = 1'b1;
    else                        stop_d = stop_q;
    if (watch_hit)    err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      pend_q <= 1'b0;
      stop_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      pend_q <= pend_d;
      stop_q <= stop_d;
      err_q  <= err_d;
    end
  end

  assign gap_irq = irq_q;
  assign stop_tx = stop_q;
  assign wt_err  = err_q;

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wt_err) |-> $past(watch_hit));

  // R10
  stop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_tx) |-> $past(slot_trig && pend_q));

  // R10
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !stop_tx);
endmodule

// File: rtl/ttc_slave_sync.sv
module ttc_slave_sync
  import ttc_pkg::*;
#(
  parameter int unsigned TW = TIME_W,
  parameter int unsigned CW = CYC_W,
  parameter int unsigned NM = N_MARK
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [TW-1:0]         local_time,
  input  logic                  sof_evt,
  input  logic                  rx_ok_evt,
  input  logic                  rx_is_ref,
  input  logic [CW-1:0]         rx_cycle,
  input  logic                  rx_gap,
  input  logic [NM-1:0][TW-1:0] tmark,
  input  logic [TW-1:0]         ref_slot_mark,
  input  logic [TW-1:0]         init_watch_mark,
  input  logic [TW-1:0]         watch_mark,
  input  logic                  wt_err_clr,
  output logic [TW-1:0]         ref_mark,
  output logic [TW-1:0]         cycle_time,
  output logic [CW-1:0]         cycle_cnt,
  output logic                  ref_seen,
  output logic [NM-1:0]         tmark_trig,
  output logic                  ref_slot_trig,
  output logic                  init_watch_en,
  output logic                  watch_en,
  output logic                  watch_trig,
  output logic                  wt_err,
  output logic                  gap_irq,
  output logic                  stop_tx
);
  localparam int unsigned NC   = NM + 2;
  localparam int unsigned SLOT = NM;
  localparam int unsigned WTCH = NM + 1;

  logic                  rst_n_s;
  logic                  accept;
  logic [NC-1:0][TW-1:0] cmp_marks;
  logic [NC-1:0]         cmp_en;
  logic [NC-1:0]         cmp_trig;

  ttc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ttc_ref_tracker #(.TW(TW), .CW(CW)) u_trk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .local_time (local_time),
    .sof_evt    (sof_evt),
    .rx_ok_evt  (rx_ok_evt),
    .rx_is_ref  (rx_is_ref),
    .rx_cycle   (rx_cycle),
    .ref_mark   (ref_mark),
    .cycle_cnt  (cycle_cnt),
    .ref_seen   (ref_seen),
    .accept     (accept)
  );

  assign cycle_time    = local_time - ref_mark;
  assign init_watch_en = !ref_seen;
  assign watch_en      = ref_seen;

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      cmp_marks[i] = tmark[i];
      cmp_en[i]    = ref_seen;
    end
    cmp_marks[SLOT] = ref_slot_mark;
    cmp_en[SLOT]    = ref_seen;
    cmp_marks[WTCH] = watch_en ? watch_mark : init_watch_mark;
    cmp_en[WTCH]    = 1'b1;
  end

  ttc_cmp_bank #(.TW(TW), .N(NC)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cycle_time (cycle_time),
    .marks      (cmp_marks),
    .en         (cmp_en),
    .trig       (cmp_trig)
  );

  assign tmark_trig    = cmp_trig[NM-1:0];
  assign ref_slot_trig = cmp_trig[SLOT];
  assign watch_trig    = cmp_trig[WTCH];

  ttc_watch_ctrl u_wdg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .accept    (accept),
    .rx_gap    (rx_gap),
    .slot_trig (ref_slot_trig),
    .watch_hit (watch_trig),
    .err_clr   (wt_err_clr),
    .gap_irq   (gap_irq),
    .stop_tx   (stop_tx),
    .wt_err    (wt_err)
  );

  // R5
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ref_seen |=> (tmark_trig == '0) && !ref_slot_trig);

  // R7
  watch_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(watch_en) |-> $past(rx_ok_evt && rx_is_ref));
endmodule

// File: tb/ttc_slave_sync_bench.sv
module ttc_slave_sync_bench;
  localparam time CLK_P = 4ns;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [15:0]      lt;
  logic             sof, rx_ok, rx_ref, rx_gap, clr;
  logic [5:0]       rx_cyc;
  logic [5:0][15:0] tmark;
  logic [15:0]      rslot, iwmark, wmark;

  logic [15:0] ref_mark, cycle_time;
  logic [5:0]  cycle_cnt, tmark_trig;
  logic        ref_seen, ref_slot_trig, init_watch_en, watch_en, watch_trig;
  logic        wt_err, gap_irq, stop_tx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  logic [15:0] m_stamp, m_ref;
  logic [5:0]  m_cnt;
  logic        m_seen, m_irq, m_pend, m_stop, m_err;
  logic [7:0]  m_mq, m_trig;

  always #(CLK_P/2) clk = ~clk;

  ttc_slave_sync u_ttc_slave_sync (
    .clk(clk), .rst_n(rst_n), .local_time(lt), .sof_evt(sof),
    .rx_ok_evt(rx_ok), .rx_is_ref(rx_ref), .rx_cycle(rx_cyc), .rx_gap(rx_gap),
    .tmark(tmark), .ref_slot_mark(rslot), .init_watch_mark(iwmark),
    .watch_mark(wmark), .wt_err_clr(clr), .ref_mark(ref_mark),
    .cycle_time(cycle_time), .cycle_cnt(cycle_cnt), .ref_seen(ref_seen),
    .tmark_trig(tmark_trig), .ref_slot_trig(ref_slot_trig),
    .init_watch_en(init_watch_en), .watch_en(watch_en),
    .watch_trig(watch_trig), .wt_err(wt_err), .gap_irq(gap_irq),
    .stop_tx(stop_tx)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_stamp = '0; m_ref = '0; m_cnt = '0; m_seen = 1'b0;
    m_irq = 1'b0; m_pend = 1'b0; m_stop = 1'b0; m_err = 1'b0;
    m_mq = '0; m_trig = '0;
  endtask

  task automatic check_all();
    chk("R1 ref_mark", ref_mark, m_ref);
    chk("R4 cycle_time", cycle_time, 16'(lt - m_ref));
    chk("R3 cycle_cnt", cycle_cnt, m_cnt);
    chk("R7 ref_seen", ref_seen, m_seen);
    chk("R7 init_watch_en", init_watch_en, !m_seen);
    chk("R7 watch_en", watch_en, m_seen);
    chk("R5 tmark_trig", tmark_trig, m_trig[5:0]);
    chk("R6 ref_slot_trig", ref_slot_trig, m_trig[6]);
    chk("R8 watch_trig", watch_trig, m_trig[7]);
    chk("R8 wt_err", wt_err, m_err);
    chk("R9 gap_irq", gap_irq, m_irq);
    chk("R10 stop_tx", stop_tx, m_stop);
  endtask

  // one clock: model advances over the rising edge, outputs checked at the falling edge
  task automatic tick();
    logic [7:0]  hit;
    logic [15:0] ct, wm;
    logic        acc;
    ct  = lt - m_ref;
    wm  = m_seen ? wmark : iwmark;
    for (int i = 0; i < 6; i++) hit[i] = m_seen && (ct == tmark[i]);
    hit[6] = m_seen && (ct == rslot);
    hit[7] = (ct == wm);
    acc = rx_ok && rx_ref;
    @(posedge clk);
    m_err  = m_trig[7] ? 1'b1 : (clr ? 1'b0 : m_err);
    m_stop = acc ? 1'b0 : ((m_pend && m_trig[6]) ? 1'b1 : m_stop);
    m_pend = acc ? rx_gap : m_pend;
    m_irq  = acc && rx_gap;
    m_trig = hit & ~m_mq;
    m_mq   = hit;
    if (acc) begin
      m_ref  = m_stamp;
      m_cnt  = rx_cyc;
      m_seen = 1'b1;
    end
    if (sof) m_stamp = lt;
    @(negedge clk);
    check_all();
    sof = 1'b0; rx_ok = 1'b0; rx_ref = 1'b0; rx_gap = 1'b0; clr = 1'b0;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      lt = lt + 16'd1;
    end
  endtask

  task automatic frame(bit ok, bit is_ref, logic [5:0] cyc, bit gap, int len);
    sof = 1'b1;
    tick(); lt = lt + 16'd1;
    run(len);
    rx_ok = ok; rx_ref = is_ref; rx_cyc = cyc; rx_gap = gap;
    tick(); lt = lt + 16'd1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int          gap_left;
    logic [15:0] sof_time;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst_n = 1'b0; lt = '0; sof = 0; rx_ok = 0; rx_ref = 0; rx_gap = 0; clr = 0;
    rx_cyc = '0;
    for (int i = 0; i < 6; i++) tmark[i] = 16'(10 + 20 * i);
    rslot = 16'd150; iwmark = 16'd40; wmark = 16'd220;
    model_reset();
    repeat (3) @(negedge clk);
    check_all();                                   // R11 during reset
    rst_n = 1'b1;
    repeat (3) begin @(negedge clk); check_all(); end  // R11 synchronizer window

    // R7/R8: no reference before the initial watch mark
    run(45);
    chk("R8 error set by initial watch", wt_err, 1'b1);
    clr = 1'b1; tick(); lt++;                      // R8 clear
    chk("R8 error cleared", wt_err, 1'b0);

    // R2: aborted frame, then a non-reference frame
    frame(1'b0, 1'b1, 6'd9, 1'b0, 6);
    frame(1'b1, 1'b0, 6'd9, 1'b0, 6);
    chk("R2 mark untouched", ref_mark, 16'd0);
    chk("R2 count untouched", cycle_cnt, 6'd0);

    // R1/R3: good reference
    sof_time = lt;
    frame(1'b1, 1'b1, 6'd5, 1'b0, 8);
    chk("R1 mark is sof stamp", ref_mark, sof_time);
    chk("R3 count copied", cycle_cnt, 6'd5);
    chk("R7 normal watch active", watch_en, 1'b1);
    run(60);

    // R9/R10: gap reference, run past the reference slot
    frame(1'b1, 1'b1, 6'd63, 1'b1, 8);
    run(150);
    chk("R10 stop asserted at slot", stop_tx, 1'b1);
    frame(1'b1, 1'b1, 6'd0, 1'b0, 4);
    chk("R10 stop cleared", stop_tx, 1'b0);

    // R4: wrap of local time
    lt = 16'hFFF0;
    frame(1'b1, 1'b1, 6'd1, 1'b0, 3);
    run(40);

    // random phase
    gap_left = 20;
    for (int k = 0; k < 5000; k++) begin
      if (($urandom % 400) == 0) begin
        for (int i = 0; i < 6; i++) tmark[i] = 16'($urandom % 200);
        rslot = 16'(120 + $urandom % 60);
      end
      clr = (($urandom % 30) == 0);
      if (gap_left == 0) begin
        gap_left = 10 + $urandom % 60;
        frame(($urandom % 4) != 0, ($urandom % 3) != 0, 6'($urandom),
              ($urandom % 4) == 0, 3 + $urandom % 15);
      end else begin
        gap_left--;
        tick();
        if (($urandom % 8) != 0) lt = lt + 16'd1;
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule